// File: doc/BRIEF.md
# Host Bus Address Latch and Cycle Decoder

This block sits at the front of a host bus slave for a memory-mapped I/O peripheral. On each rising edge of the active-low address strobe, it captures the host address, the I/O-enable qualifier, the four active-low byte enables and the data-register chip select. The captured values are held until the next strobe edge. All decode results are formed from these held values.

Decoding has three parts:

- **Device selection.** The upper address bits are compared with a base register that software loads through a simple write port. The device claims the cycle only when the I/O enable is low and the comparison matches.
- **Byte-enable decoding.** The byte-enable pattern is mapped to a transfer size, a lane mask and a byte address within the 16-byte register window. Patterns that are not accepted set an error flag and cancel the access.
- **Chip-select override.** An asserted data-register chip select skips local decoding. It forces a full-width access to the queue data register, whatever the address and byte enables are.

The bus width is fixed at build time. In 16-bit form, the two upper byte enables are not used.

Top module: `hbus_addr_decode`

## Requirements
- R1: The strobe counts as rising on a clock edge where `host_as_n` is 1 and was 0 at the previous edge. At that edge, `host_addr`, `host_aen_n`, `host_be_n` and `dreg_cs_n` are captured as presented. At every other edge the captured values, and so all outputs, stay unchanged.
- R2: After synchronous reset the block is in the no-access state:
  - `local_n`=1;
  - `qdata_sel`=0, `xfer_size`=0, `lane_en`=0, `byte_addr`=0, `be_err`=0;
  - the base register is zero.
- R3: When `base_wr` is 1 at a clock edge, the base register takes `base_wdata` at that edge. Later cycles compare against the new value.
- R4: When the captured chip select is high, `local_n` is 0 only if all of these hold:
  - the captured `host_aen_n` is 0;
  - captured address bits [15:4] equal the base register;
  - the byte-enable pattern is accepted.
- R5: A captured `host_aen_n` of 1 with the chip select high is a DMA memory cycle. It gives `local_n`=1, `xfer_size`=0, `lane_en`=0 and `be_err`=0.
- R6: In 32-bit form, `host_be_n[i]`=0 enables byte lane i (bits [8i+7:8i]). `lane_en` is the inverse of the pattern. Accepted `lane_en` values are:
  - 1111, giving size 3 (word);
  - 0011 or 1100, giving size 2 (halfword);
  - 0001, 0010, 0100 or 1000, giving size 1 (byte).
- R7: In 16-bit form, only `host_be_n[1:0]` is used, and `lane_en[3:2]` is always 0. Accepted values of `lane_en[1:0]` are 11 (size 2), 01 and 10 (size 1). `host_be_n[3:2]` has no effect on any output.
- R8: A selected cycle (chip select high, I/O enable low, address match) whose pattern is not accepted gives `be_err`=1, `local_n`=1, `xfer_size`=0 and `lane_en`=0.
- R9: A captured `dreg_cs_n` of 0 gives `local_n`=0, `qdata_sel`=1, `xfer_size`=3, `lane_en`=1111, `byte_addr`=0 and `be_err`=0. This holds whatever the address, I/O enable and byte enables are. `qdata_sel` is 0 in every other case.
- R10: For an accepted local access, `byte_addr` is {captured address[3:1], 0} bitwise-ORed with the index of the lowest enabled lane. In all other cases `byte_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_as_n | input | 1 | Address strobe, active low; capture on its rising edge |
| host_addr | input | 15 | Host address bits [15:1] |
| host_aen_n | input | 1 | I/O enable, low allows decoding |
| host_be_n | input | 4 | Byte enables, active low, bit i is lane i |
| dreg_cs_n | input | 1 | Data-register chip select, active low |
| base_wr | input | 1 | Base register write strobe |
| base_wdata | input | 12 | New base value for address bits [15:4] |
| local_n | output | 1 | Device claims the cycle, active low |
| qdata_sel | output | 1 | Access targets the queue data register |
| xfer_size | output | 2 | 0 none, 1 byte, 2 halfword, 3 word |
| lane_en | output | 4 | Active byte lanes |
| byte_addr | output | 4 | Byte address within the register window |
| be_err | output | 1 | Selected cycle with an unaccepted byte-enable pattern |

## Verification
The assertions assume that `host_as_n` goes low before each capture and that the strobe and bus inputs are stable at the sampling clock edge. The bench drives all inputs on the falling clock edge and holds them across the capture edge. It assumes a base write never lands in the same cycle as a capture it is meant to affect, so base writes are issued only between cycles. The random stimulus steers most addresses onto the programmed base, keeps the I/O enable mostly low, and asserts the chip select only rarely, so that every decode path is reached.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2,
        SZ_WORD = 2'd3
    } xfer_size_e;

    typedef struct packed {
        logic       legal;
        xfer_size_e size;
        logic [3:0] lanes;
        logic [1:0] first;
    } be_info_t;

    function automatic logic [1:0] lowest_lane(input logic [3:0] m);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (m[i]) idx = 2'(i);
        end
        return idx;
    endfunction

    function automatic be_info_t decode_be(input logic [3:0] be_n, input logic wide);
        be_info_t   r;
        logic [3:0] m;
        m = ~be_n;
        if (!wide) m[3:2] = 2'b00;
        r.legal = 1'b1;
        r.size  = SZ_NONE;
        unique case (m)
            4'b1111: r.size = SZ_WORD;
            4'b0011: r.size = SZ_HALF;
            4'b1100: r.size = SZ_HALF;
            4'b0001, 4'b0010,
            4'b0100, 4'b1000: r.size = SZ_BYTE;
            default: r.legal = 1'b0;
        endcase
        if (!wide && (m == 4'b1111 || m == 4'b1100 || m == 4'b0100 || m == 4'b1000))
            r.legal = 1'b0;
        if (r.legal) begin
            r.lanes = m;
            r.first = lowest_lane(m);
        end else begin
            r.size  = SZ_NONE;
            r.lanes = 4'b0000;
            r.first = 2'd0;
        end
        return r;
    endfunction

endpackage

// File: rtl/hbd_latch.sv
module hbd_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic [ADDR_W-1:1] addr,
    input  logic              aen_n,
    input  logic [3:0]        be_n,
    input  logic              cs_n,
    output logic [ADDR_W-1:1] lat_addr,
    output logic              lat_aen_n,
    output logic [3:0]        lat_be_n,
    output logic              lat_cs_n
);
    logic as_q;
    logic capture;

    assign capture = as_n & ~as_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_q      <= 1'b1;
            lat_addr  <= '0;
            lat_aen_n <= 1'b1;
            lat_be_n  <= 4'hF;
            lat_cs_n  <= 1'b1;
        end else begin
            as_q <= as_n;
            if (capture) begin
                lat_addr  <= addr;
                lat_aen_n <= aen_n;
                lat_be_n  <= be_n;
                lat_cs_n  <= cs_n;
            end
        end
    end

    // R1: holding registers change only on a strobe rising edge
    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !(as_n && !as_q) |=> $stable({lat_addr, lat_aen_n, lat_be_n, lat_cs_n}));

    // R1: a strobe rising edge takes the presented bus values
    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (as_n && !as_q) |=> (lat_addr == $past(addr) && lat_be_n == $past(be_n)
                             && lat_cs_n == $past(cs_n)));

endmodule

// File: rtl/hbd_be_decode.sv
module hbd_be_decode
    import hbd_pkg::*;
#(
    parameter bit BUS32 = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] be_n,
    output be_info_t   info
);
    generate
        if (BUS32) begin : g_wide
            assign info = decode_be(be_n, 1'b1);
        end else begin : g_narrow
            assign info = decode_be(be_n, 1'b0);
            // R7: upper lanes never enabled on a 16-bit bus
            assert_narrow_lanes_R7: assert property (@(posedge clk) disable iff (rst)
                info.lanes[3:2] == 2'b00);
        end
    endgenerate

    // R6: a byte access enables exactly one lane
    assert_byte_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        (info.size == SZ_BYTE) |-> ($countones(info.lanes) == 1));

endmodule

// File: rtl/hbd_base_match.sv
module hbd_base_match #(
    parameter int BASE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BASE_W-1:0] wdata,
    input  logic [BASE_W-1:0] cmp,
    output logic              hit
);
    logic [BASE_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)     base_q <= '0;
        else if (wr) base_q <= wdata;
    end

    assign hit = (cmp == base_q);

    // R3: a write lands in the base register at the next edge
    assert_base_load_R3: assert property (@(posedge clk) disable iff (rst)
        wr |=> (base_q == $past(wdata)));

endmodule

// File: rtl/hbus_addr_decode.sv
module hbus_addr_decode
    import hbd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 4,
    parameter bit BUS32  = 1'b1,
    localparam int BASE_W = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_as_n,
    input  logic [ADDR_W-1:1] host_addr,
    input  logic              host_aen_n,
    input  logic [3:0]        host_be_n,
    input  logic              dreg_cs_n,
    input  logic              base_wr,
    input  logic [BASE_W-1:0] base_wdata,
    output logic              local_n,
    output logic              qdata_sel,
    output logic [1:0]        xfer_size,
    output logic [3:0]        lane_en,
    output logic [OFFS_W-1:0] byte_addr,
    output logic              be_err
);
    logic [ADDR_W-1:1] lat_addr;
    logic              lat_aen_n;
    logic [3:0]        lat_be_n;
    logic              lat_cs_n;
    logic              hit;
    be_info_t          info;

    hbd_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk(clk), .rst(rst), .as_n(host_as_n), .addr(host_addr),
        .aen_n(host_aen_n), .be_n(host_be_n), .cs_n(dreg_cs_n),
        .lat_addr(lat_addr), .lat_aen_n(lat_aen_n),
        .lat_be_n(lat_be_n), .lat_cs_n(lat_cs_n)
    );

    hbd_base_match #(.BASE_W(BASE_W)) u_match (
        .clk(clk), .rst(rst), .wr(base_wr), .wdata(base_wdata),
        .cmp(lat_addr[ADDR_W-1:OFFS_W]), .hit(hit)
    );

    hbd_be_decode #(.BUS32(BUS32)) u_bedec (
        .clk(clk), .rst(rst), .be_n(lat_be_n), .info(info)
    );

    logic io_sel;
    assign io_sel = ~lat_aen_n & hit;

    always_comb begin
        local_n   = 1'b1;
        qdata_sel = 1'b0;
        xfer_size = SZ_NONE;
        lane_en   = 4'b0000;
        byte_addr = '0;
        be_err    = 1'b0;
        if (!lat_cs_n) begin
            local_n   = 1'b0;
            qdata_sel = 1'b1;
            xfer_size = SZ_WORD;
            lane_en   = 4'b1111;
        end else if (io_sel && info.legal) begin
            local_n   = 1'b0;
            xfer_size = info.size;
            lane_en   = info.lanes;
            byte_addr = {lat_addr[OFFS_W-1:1], 1'b0} | OFFS_W'(info.first);
        end else if (io_sel) begin
            be_err    = 1'b1;
        end
    end

    // R8: an error cancels the access
    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        be_err |-> (local_n && lane_en == 4'b0000 && xfer_size == SZ_NONE));

    // R5: a DMA cycle is never claimed
    assert_dma_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (lat_aen_n && lat_cs_n) |-> (local_n && !be_err));

    // R9: chip select forces a full-width data register access
    assert_dreg_word_R9: assert property (@(posedge clk) disable iff (rst)
        qdata_sel |-> (!local_n && xfer_size == SZ_WORD && lane_en == 4'hF && !be_err));

    // R4: a claim always carries a transfer size
    assert_claim_sized_R4: assert property (@(posedge clk) disable iff (rst)
        !local_n |-> (xfer_size != SZ_NONE));

endmodule

// File: tb/hbus_addr_decode_bench.sv
`timescale 1ns/1ps
module hbus_addr_decode_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1;
    logic [15:1] addr = '0;
    logic        aen_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        cs_n = 1'b1;
    logic        bwr = 1'b0;
    logic [11:0] bdat = '0;
    logic [11:0] base_m = '0;

    logic       w_local, w_q, w_err, n_local, n_q, n_err;
    logic [1:0] w_size, n_size;
    logic [3:0] w_lane, n_lane, w_ba, n_ba;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hbus_addr_decode u_hbus_addr_decode (
        .clk(clk), .rst(rst), .host_as_n(as_n), .host_addr(addr),
        .host_aen_n(aen_n), .host_be_n(be_n), .dreg_cs_n(cs_n),
        .base_wr(bwr), .base_wdata(bdat), .local_n(w_local), .qdata_sel(w_q),
        .xfer_size(w_size), .lane_en(w_lane), .byte_addr(w_ba), .be_err(w_err)
    );

    hbus_addr_decode #(.BUS32(1'b0)) u_hbus_addr_decode_w16 (
        .clk(clk), .rst(rst), .host_as_n(as_n), .host_addr(addr),
        .host_aen_n(aen_n), .host_be_n(be_n), .dreg_cs_n(cs_n),
        .base_wr(bwr), .base_wdata(bdat), .local_n(n_local), .qdata_sel(n_q),
        .xfer_size(n_size), .lane_en(n_lane), .byte_addr(n_ba), .be_err(n_err)
    );

    // {local_n, qdata_sel, size[1:0], lanes[3:0], byte_addr[3:0], err}
    function automatic logic [12:0] model(bit wide, logic [15:1] a, logic aen,
                                          logic [3:0] be, logic cs, logic [11:0] base);
        logic [3:0] m;
        logic       ok;
        logic [1:0] sz;
        logic [1:0] fl;
        if (!cs) return {1'b0, 1'b1, 2'd3, 4'hF, 4'h0, 1'b0};
        if (aen || a[15:4] != base) return {1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 1'b0};
        m = wide ? ~be : {2'b00, ~be[1:0]};
        if (wide) ok = (m == 4'hF || m == 4'h3 || m == 4'hC || m == 4'h1 ||
                        m == 4'h2 || m == 4'h4 || m == 4'h8);
        else      ok = (m != 4'h0);
        if (!ok) return {1'b1, 1'b0, 2'd0, 4'h0, 4'h0, 1'b1};
        sz = ($countones(m) == 4) ? 2'd3 : ($countones(m) == 2) ? 2'd2 : 2'd1;
        fl = m[0] ? 2'd0 : m[1] ? 2'd1 : m[2] ? 2'd2 : 2'd3;
        return {1'b0, 1'b0, sz, m, {a[3:1], 1'b0} | {2'b00, fl}, 1'b0};
    endfunction

    task automatic check(string req, logic [12:0] got, logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_both(string req, logic [15:1] a, logic aen, logic [3:0] be, logic cs);
        check({req, " w32"}, {w_local, w_q, w_size, w_lane, w_ba, w_err},
              model(1'b1, a, aen, be, cs, base_m));
        check({req, " w16"}, {n_local, n_q, n_size, n_lane, n_ba, n_err},
              model(1'b0, a, aen, be, cs, base_m));
    endtask

    task automatic bus_cycle(logic [15:1] a, logic aen, logic [3:0] be, logic cs);
        @(negedge clk);
        addr = a; aen_n = aen; be_n = be; cs_n = cs; as_n = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_base(logic [11:0] v);
        @(negedge clk);
        bwr = 1'b1; bdat = v;
        @(negedge clk);
        bwr = 1'b0;
        base_m = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:1] a;
        logic [3:0]  be;
        logic        aen, cs;
        logic [3:0]  pats [7] = '{4'h0, 4'hC, 4'h3, 4'hE, 4'hD, 4'hB, 4'h7};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: reset state
        check_both("R2 reset", 15'h0, 1'b1, 4'hF, 1'b1);

        // R2: base register zero after reset (address 0 page is selected)
        bus_cycle(15'h0002, 1'b0, 4'h0, 1'b1);
        check_both("R2 base zero", 15'h0002, 1'b0, 4'h0, 1'b1);

        // R3: new base
        load_base(12'h0A5);
        bus_cycle({12'h0A5, 3'b010}, 1'b0, 4'h0, 1'b1);
        check_both("R3 R6 word after base write", {12'h0A5, 3'b010}, 1'b0, 4'h0, 1'b1);

        // R6 R7 R10: every accepted pattern, two offsets
        foreach (pats[i]) begin
            bus_cycle({12'h0A5, 3'b001}, 1'b0, pats[i], 1'b1);
            check_both("R6 R7 R10 pattern", {12'h0A5, 3'b001}, 1'b0, pats[i], 1'b1);
            bus_cycle({12'h0A5, 3'b110}, 1'b0, pats[i], 1'b1);
            check_both("R6 R7 R10 pattern", {12'h0A5, 3'b110}, 1'b0, pats[i], 1'b1);
        end

        // R8: unaccepted patterns
        bus_cycle({12'h0A5, 3'b000}, 1'b0, 4'b1010, 1'b1);
        check_both("R8 illegal pattern", {12'h0A5, 3'b000}, 1'b0, 4'b1010, 1'b1);
        bus_cycle({12'h0A5, 3'b000}, 1'b0, 4'hF, 1'b1);
        check_both("R8 no lanes", {12'h0A5, 3'b000}, 1'b0, 4'hF, 1'b1);

        // R7: upper byte enables ignored on the 16-bit bus
        bus_cycle({12'h0A5, 3'b011}, 1'b0, 4'b0110, 1'b1);
        check_both("R7 upper be ignored", {12'h0A5, 3'b011}, 1'b0, 4'b0110, 1'b1);

        // R5: DMA cycle
        bus_cycle({12'h0A5, 3'b000}, 1'b1, 4'h0, 1'b1);
        check_both("R5 dma cycle", {12'h0A5, 3'b000}, 1'b1, 4'h0, 1'b1);

        // R4: address mismatch
        bus_cycle({12'h0A4, 3'b000}, 1'b0, 4'h0, 1'b1);
        check_both("R4 mismatch", {12'h0A4, 3'b000}, 1'b0, 4'h0, 1'b1);

        // R9: chip select override with junk
        bus_cycle(15'h7FFF, 1'b1, 4'b1010, 1'b0);
        check_both("R9 chip select", 15'h7FFF, 1'b1, 4'b1010, 1'b0);

        // R1: inputs moving without a strobe edge change nothing
        bus_cycle({12'h0A5, 3'b101}, 1'b0, 4'hE, 1'b1);
        @(negedge clk);
        addr = 15'h1234; aen_n = 1'b1; be_n = 4'h0; cs_n = 1'b0;
        repeat (3) @(negedge clk);
        check_both("R1 hold", {12'h0A5, 3'b101}, 1'b0, 4'hE, 1'b1);

        // R1 R4 R6 R7 R8 R10: random mix
        for (int k = 0; k < 400; k++) begin
            if (k % 100 == 50) load_base(12'($urandom));
            a   = 15'($urandom);
            if ($urandom % 4 != 0) a[15:4] = base_m;
            aen = ($urandom % 5 == 0);
            cs  = ($urandom % 8 != 0);
            be  = ($urandom % 2) ? pats[$urandom % 7] : 4'($urandom);
            bus_cycle(a, aen, be, cs);
            check_both("R1 R4 R6 R7 R8 R10 random", a, aen, be, cs);
        end

        finish_run();
    end
endmodule